// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block services a translation miss. It takes the effective address that missed, a table base address and an indexing-mode select. It then reads two 32-bit descriptors from memory through a simple request/response port. The first read uses an address formed from the base and the high bits of the effective address. The level one descriptor gives the base of a level two table and a page-size code. The level two descriptor gives the physical page bits.

The block combines those page bits with the low effective address bits to form the physical address. It returns that address, the level two descriptor and the page-size code, which the translation buffer needs for its reload. If either descriptor has its valid bit clear, the walk ends in a fault. The fault output reports which level failed. Large pages need no special indexing, because software duplicates their table entries.

Top module: `twk_engine`

## Requirements
- R1: While reset is asserted and after it is released with no start, `busy`, `mem_req`, `done` and `fault` are all low.
- R2: With `mode` = 1, the first read address is tbase[31:12], ea[31:22], 2'b00, concatenated in that order (bit 31 is the most significant bit).
- R3: With `mode` = 0, the first read address is tbase[31:14], ea[31:20], 2'b00, concatenated in that order.
- R4: The second read address is L1desc[31:12], idx, 2'b00, concatenated in that order. idx is ea[21:12] in mode 1 and ea[19:10] in mode 0.
- R5: Descriptor layout is as follows. L1 has its level two base in [31:12], the page-size code in [2:1] and valid in [0]. L2 has its page bits in [31:10] and valid in [0].
- R6: The page-size code picks the number of low effective address bits that pass through to `real_addr`. In mode 1, codes 0/1/2/3 give 12/14/19/23 bits. In mode 0 they give 10/14/19/23 bits. All higher bits come from the L2 descriptor.
- R7: When `done` is high, `l2_desc` equals the level two descriptor that was read and `page_code` equals L1desc[2:1].
- R8: An L1 descriptor with valid = 0 ends the walk with `fault` high and `fault_lvl` = 0, and no second read is issued.
- R9: An L2 descriptor with valid = 0 ends the walk with `fault` high and `fault_lvl` = 1.
- R10: `busy` goes high in the cycle after an accepted start and stays high until the single-cycle `done` or `fault` pulse, which are never high together. A start while busy has no effect on the walk.
- R11: Each read is a one-cycle `mem_req` pulse. `mem_addr` holds until `rsp_valid` arrives, and any number of wait cycles is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| ea | input | 32 | Effective address that missed |
| tbase | input | 32 | Level one table base |
| mode | input | 1 | Indexing mode select |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 32 | Descriptor read address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data |
| done | output | 1 | Walk completed pulse |
| fault | output | 1 | Walk failed pulse |
| fault_lvl | output | 1 | Failing level (0 = L1, 1 = L2) |
| real_addr | output | 32 | Physical address |
| l2_desc | output | 32 | Level two descriptor for reload |
| page_code | output | 2 | Page-size code |

## Verification
The hardest case to reach is the interplay between a new start and an outstanding read. This means a second start arriving mid-walk, or a response coming after several idle wait cycles while the address must hold. The bench's memory model inserts a configurable number of wait cycles before each response. A separate pass raises start with a different address and mode during a walk and expects the original walk's results unchanged. The model also computes descriptors arithmetically from the address. The bench sweeps both modes, all four page codes, the all-zero and all-one effective addresses and injected invalid descriptors at each level.

// File: rtl/twk_pkg.sv
package twk_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE, S_FAULT
   } twk_state_e;
   localparam int VLD_BIT  = 0;
   localparam int CODE_LSB = 1;
   localparam int CODE_W   = 2;
endpackage

// File: rtl/twk_ctrl.sv
module twk_ctrl
   import twk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic rsp_valid,
   input  logic rsp_ok,
   output logic accept,
   output logic cap_l1,
   output logic cap_l2,
   output logic req,
   output logic sel_l2,
   output logic busy,
   output logic done,
   output logic fault,
   output logic fault_lvl
);
   twk_state_e st_q, st_d;
   logic       lvl_q, lvl_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= S_IDLE;
         lvl_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         lvl_q <= lvl_d;
      end
   end

   always_comb begin
      st_d  = st_q;
      lvl_d = lvl_q;
      unique case (st_q)
         S_IDLE:    if (start) st_d = S_L1_REQ;
         S_L1_REQ:  st_d = S_L1_WAIT;
         S_L1_WAIT: if (rsp_valid) begin
                       if (rsp_ok) st_d = S_L2_REQ;
                       else begin st_d = S_FAULT; lvl_d = 1'b0; end
                    end
         S_L2_REQ:  st_d = S_L2_WAIT;
         S_L2_WAIT: if (rsp_valid) begin
                       if (rsp_ok) st_d = S_DONE;
                       else begin st_d = S_FAULT; lvl_d = 1'b1; end
                    end
         default:   st_d = S_IDLE;
      endcase
   end

   assign accept    = (st_q == S_IDLE) && start;
   assign cap_l1    = (st_q == S_L1_WAIT) && rsp_valid;
   assign cap_l2    = (st_q == S_L2_WAIT) && rsp_valid;
   assign req       = (st_q == S_L1_REQ) || (st_q == S_L2_REQ);
   assign sel_l2    = (st_q == S_L2_REQ) || (st_q == S_L2_WAIT);
   assign busy      = (st_q == S_L1_REQ) || (st_q == S_L1_WAIT) ||
                      (st_q == S_L2_REQ) || (st_q == S_L2_WAIT);
   assign done      = (st_q == S_DONE);
   assign fault     = (st_q == S_FAULT);
   assign fault_lvl = lvl_q;
endmodule

// File: rtl/twk_desc_addr.sv
module twk_desc_addr #(
   parameter int AW    = 32,
   parameter int IDX_N = 10,
   parameter int IDX_W = 12,
   parameter int L2I   = 10
) (
   input  logic          mode,
   input  logic          sel_l2,
   input  logic [AW-1:0] tb,
   input  logic [AW-1:0] ea,
   input  logic [AW-1:0] l1d,
   output logic [AW-1:0] addr
);
   localparam int HI_N = AW - 1 - IDX_N;
   localparam int HI_W = AW - 1 - IDX_W;

   logic [AW-1:0]  a1_n, a1_w, a2;
   logic [L2I-1:0] idx2;

   assign a1_n = {tb[AW-1:IDX_N+2], ea[AW-1 -: IDX_N], 2'b00};
   assign a1_w = {tb[AW-1:IDX_W+2], ea[AW-1 -: IDX_W], 2'b00};
   assign idx2 = mode ? ea[HI_N -: L2I] : ea[HI_W -: L2I];
   assign a2   = {l1d[AW-1:L2I+2], idx2, 2'b00};
   assign addr = sel_l2 ? a2 : (mode ? a1_n : a1_w);
endmodule

// File: rtl/twk_ra_merge.sv
module twk_ra_merge #(
   parameter int AW    = 32,
   parameter int OFF_N = 12,
   parameter int OFF_W = 10,
   parameter int LG1   = 14,
   parameter int LG2   = 19,
   parameter int LG3   = 23
) (
   input  logic          mode,
   input  logic [1:0]    code,
   input  logic [AW-1:0] page,
   input  logic [AW-1:0] ea,
   output logic [AW-1:0] ra
);
   logic [AW-1:0] msk [4];
   logic [AW-1:0] m;

   for (genvar k = 0; k < 4; k++) begin : g_sz
      if (k == 0) begin : g_base
         localparam logic [AW-1:0] MN = {{(AW-OFF_N){1'b0}}, {OFF_N{1'b1}}};
         localparam logic [AW-1:0] MW = {{(AW-OFF_W){1'b0}}, {OFF_W{1'b1}}};
         assign msk[k] = mode ? MN : MW;
      end else begin : g_large
         localparam int NB = (k == 1) ? LG1 : (k == 2) ? LG2 : LG3;
         localparam logic [AW-1:0] ML = {{(AW-NB){1'b0}}, {NB{1'b1}}};
         assign msk[k] = ML;
      end
   end

   assign m  = msk[code];
   assign ra = (page & ~m) | (ea & m);
endmodule

// File: rtl/twk_engine.sv
module twk_engine
   import twk_pkg::*;
#(
   parameter int AW       = 32,
   parameter int L1_IDX_N = 10,
   parameter int L1_IDX_W = 12,
   parameter int L2_IDX   = 10,
   parameter int LG1      = 14,
   parameter int LG2      = 19,
   parameter int LG3      = 23
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] ea,
   input  logic [AW-1:0] tbase,
   input  logic          mode,
   output logic          busy,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          rsp_valid,
   input  logic [AW-1:0] rsp_data,
   output logic          done,
   output logic          fault,
   output logic          fault_lvl,
   output logic [AW-1:0] real_addr,
   output logic [AW-1:0] l2_desc,
   output logic [1:0]    page_code
);
   localparam int OFF_N = AW - L1_IDX_N - L2_IDX;
   localparam int OFF_W = AW - L1_IDX_W - L2_IDX;

   if (L1_IDX_W <= L1_IDX_N) begin : g_chk_idx
      $error("wide level one index must exceed narrow index");
   end
   if (OFF_W < 3 || L2_IDX + 2 > OFF_W + L2_IDX) begin : g_chk_off
      $error("page offset too small for descriptor layout");
   end
   if (!(LG1 > OFF_N && LG2 > LG1 && LG3 > LG2 && LG3 < AW)) begin : g_chk_lg
      $error("large page sizes must be increasing and fit the address");
   end

   logic          accept, cap_l1, cap_l2, sel_l2;
   logic [AW-1:0] ea_q, tb_q, d1_q, d2_q;
   logic          mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ea_q   <= '0;
         tb_q   <= '0;
         mode_q <= 1'b0;
         d1_q   <= '0;
         d2_q   <= '0;
      end else begin
         if (accept) begin
            ea_q   <= ea;
            tb_q   <= tbase;
            mode_q <= mode;
         end
         if (cap_l1) d1_q <= rsp_data;
         if (cap_l2) d2_q <= rsp_data;
      end
   end

   twk_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .rsp_valid(rsp_valid),
      .rsp_ok(rsp_data[VLD_BIT]), .accept(accept), .cap_l1(cap_l1),
      .cap_l2(cap_l2), .req(mem_req), .sel_l2(sel_l2), .busy(busy),
      .done(done), .fault(fault), .fault_lvl(fault_lvl)
   );

   twk_desc_addr #(.AW(AW), .IDX_N(L1_IDX_N), .IDX_W(L1_IDX_W), .L2I(L2_IDX)) u_addr (
      .mode(mode_q), .sel_l2(sel_l2), .tb(tb_q), .ea(ea_q), .l1d(d1_q),
      .addr(mem_addr)
   );

   twk_ra_merge #(.AW(AW), .OFF_N(OFF_N), .OFF_W(OFF_W),
                  .LG1(LG1), .LG2(LG2), .LG3(LG3)) u_merge (
      .mode(mode_q), .code(d1_q[CODE_LSB +: CODE_W]), .page(d2_q),
      .ea(ea_q), .ra(real_addr)
   );

   assign l2_desc   = d2_q;
   assign page_code = d1_q[CODE_LSB +: CODE_W];
endmodule

// File: rtl/twk_chk.sv
module twk_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          mem_req,
   input logic [AW-1:0] mem_addr,
   input logic          rsp_valid,
   input logic          done,
   input logic          fault
);
   p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   p_req_in_walk_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);
   p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_req && !rsp_valid) |=> $stable(mem_addr));
   p_end_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));
   p_end_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fault) |-> !busy);
   p_end_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fault) |=> !(done || fault));
   p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done || fault));
endmodule

bind twk_engine twk_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mem_req(mem_req),
   .mem_addr(mem_addr), .rsp_valid(rsp_valid), .done(done), .fault(fault)
);

// File: tb/sim_twk_engine.sv
`timescale 1ns/1ps
module sim_twk_engine;
   localparam logic [31:0] TB = 32'h0010_0000;

   logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
   logic [31:0] ea = '0, tbase = TB;
   logic        busy, mem_req, rsp_valid = 1'b0, done, fault, fault_lvl;
   logic [31:0] mem_addr, rsp_data = '0, real_addr, l2_desc;
   logic [1:0]  page_code;

   int total = 0, bad = 0, cyc = 0;
   int n_req = 0, lat = 0;
   logic [31:0] req_a [2];
   logic [1:0]  cfg_code = 2'd0;
   bit          l1_bad = 0, l2_bad = 0;

   always #2 clk = ~clk;

   twk_engine u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .tbase(tbase),
      .mode(mode), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done), .fault(fault),
      .fault_lvl(fault_lvl), .real_addr(real_addr), .l2_desc(l2_desc),
      .page_code(page_code)
   );

   function automatic logic [31:0] mem_fn(input logic [31:0] a);
      logic [31:0] i;
      if (a >= TB && a < TB + 32'h4000) begin
         i = (a - TB) >> 2;
         return (32'h0800_0000 + (i << 12)) | {29'd0, cfg_code, !l1_bad};
      end
      return (((a * 32'h9E37_79B1) ^ (a >> 7)) & 32'hFFFF_FC00) | {31'd0, !l2_bad};
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++; bad++;
         $display("FAIL R10 watchdog actual=%0d expected=<150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // memory responder: sees a request at a negedge, answers after lat cycles
   initial begin
      forever begin
         @(negedge clk);
         rsp_valid = 1'b0;
         if (mem_req) begin
            logic [31:0] a;
            a = mem_addr;
            if (n_req < 2) req_a[n_req] = a;
            n_req++;
            for (int w = 0; w < lat; w++) begin
               @(negedge clk);
               chk(mem_addr == a, "R11 hold", mem_addr, a);
            end
            @(negedge clk);
            rsp_valid = 1'b1;
            rsp_data  = mem_fn(a);
         end
      end
   end

   task automatic walk(input logic m, input logic [31:0] e, input logic [1:0] c,
                       input bit b1, input bit b2, input int lt, input bit poke);
      logic [31:0] l1e, l2e, d1, d2, msk, ra;
      int offs, t;
      cfg_code = c; l1_bad = b1; l2_bad = b2; lat = lt; n_req = 0;
      @(negedge clk);
      start = 1'b1; ea = e; mode = m;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R10 busy", {31'd0, busy}, 32'd1);
      if (poke) begin
         start = 1'b1; ea = ~e; mode = ~m;
         @(negedge clk);
         start = 1'b0;
         chk(busy == 1'b1, "R10 busy on ignored start", {31'd0, busy}, 32'd1);
      end
      t = 0;
      while (!(done || fault) && t < 60) begin
         @(negedge clk);
         t++;
      end
      l1e = m ? {TB[31:12], e[31:22], 2'b00} : {TB[31:14], e[31:20], 2'b00};
      chk(req_a[0] == l1e, m ? "R2 L1 addr" : "R3 L1 addr", req_a[0], l1e);
      d1  = mem_fn(l1e);
      l2e = {d1[31:12], (m ? e[21:12] : e[19:10]), 2'b00};
      chk(!(done && fault), "R10 exclusive", {30'd0, done, fault}, 32'd0);
      if (b1) begin
         chk(fault && !fault_lvl, "R8 L1 fault", {30'd0, fault, fault_lvl}, 32'd2);
         chk(n_req == 1, "R8 no second read", n_req, 32'd1);
      end else begin
         chk(req_a[1] == l2e, "R4 L2 addr", req_a[1], l2e);
         d2 = mem_fn(l2e);
         if (b2) begin
            chk(fault && fault_lvl, "R9 L2 fault", {30'd0, fault, fault_lvl}, 32'd3);
         end else begin
            offs = (c == 0) ? (m ? 12 : 10) : (c == 1) ? 14 : (c == 2) ? 19 : 23;
            msk  = (32'd1 << offs) - 32'd1;
            ra   = (d2 & ~msk) | (e & msk);
            chk(done == 1'b1, "R5 done", {31'd0, done}, 32'd1);
            chk(real_addr == ra, "R6 real addr", real_addr, ra);
            chk(l2_desc == d2, "R7 descriptor", l2_desc, d2);
            chk(page_code == c, "R7 page code", {30'd0, page_code}, {30'd0, c});
         end
      end
      @(negedge clk);
      chk(!done && !fault && !busy, "R10 pulse end", {29'd0, busy, done, fault}, 32'd0);
   endtask

   initial begin
      logic [31:0] e;
      repeat (3) @(negedge clk);
      chk(!busy && !mem_req && !done && !fault, "R1 in reset",
          {28'd0, busy, mem_req, done, fault}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!busy && !mem_req && !done && !fault, "R1 idle",
          {28'd0, busy, mem_req, done, fault}, 32'd0);
      e = 32'h1234_5678;
      for (int md = 0; md < 2; md++)
         for (int c = 0; c < 4; c++)
            for (int j = 0; j < 12; j++) begin
               logic [31:0] ev;
               e  = e * 32'd1664525 + 32'd1013904223;
               ev = (j == 0) ? 32'h0 : (j == 1) ? 32'hFFFF_FFFF : e;
               walk(md[0], ev, c[1:0], 0, 0, j % 4, 0);
            end
      for (int md = 0; md < 2; md++) begin
         walk(md[0], 32'hA5C3_0F17, 2'd1, 1, 0, 2, 0);
         walk(md[0], 32'h3C0F_F0E1, 2'd2, 0, 1, 0, 0);
         walk(md[0], 32'h7E81_4422, 2'd3, 0, 0, 3, 1);
         walk(md[0], 32'hDEAD_BEEF, 2'd0, 0, 0, 0, 1);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule